// File: doc/BRIEF.md
# ADC Conversion Settling Filter

This block sits behind an analog-to-digital converter and decides which conversion results are allowed into a status register. Each result arrives with a one-cycle done strobe. The block keeps only the upper bits of each result as a comparison key. In filtered mode, the status register changes only after the key has been the same for a run of consecutive conversions. In bypass mode, every conversion is written through.

Software or downstream logic reads the status value. It uses the update strobe to learn that a fresh, settled value has arrived. Small jitter in the low bits of the converter never breaks a run, because those bits take no part in the comparison.

Top module: `adc_settle_filter`

## Requirements
- R1: A synchronous active-high `rst` clears the status value to 0, holds `status_upd` low and empties the run history. After release, the first conversion starts a new run of length 1.
- R2: With `filt_bypass` = 0 (the filtering default), the status register is written by the conversion that completes a run of 4 consecutive conversions with equal keys. The three conversions before it in that run do not write it.
- R3: The key of a result is its 6 most significant bits, `conv_data[7:2]`. Differences in `conv_data[1:0]` never break a run. On a write, `status_q` takes the key of the conversion being accepted.
- R4: A conversion whose key differs from the previous conversion's key restarts the run at length 1 and does not write the status register in filtered mode. Three further matching conversions are then needed.
- R5: Once a run has reached 4, the run length saturates. Each further conversion with the same key writes the status register again in filtered mode.
- R6: With `filt_bypass` = 1, every conversion writes its key to `status_q` and pulses `status_upd`.
- R7: `status_upd` is high for exactly the one cycle after the clock edge that accepts a written conversion. Without `conv_valid`, `status_q` holds and `status_upd` stays low.
- R8: Run tracking continues while bypass is active. Conversions accepted in bypass count toward a run that completes after returning to filtered mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_valid | input | 1 | One-cycle strobe: a conversion result is present |
| conv_data | input | 8 | Conversion result |
| filt_bypass | input | 1 | 1 = write every conversion, 0 = require a settled run |
| status_q | output | 6 | Status value: key of the last accepted conversion |
| status_upd | output | 1 | Pulses for one cycle when `status_q` is written |

## Verification
The bench builds the block with its default parameters: an 8-bit result, a 6-bit key and a run length of 4. These values make every run boundary short enough to step through by hand. Runs of three and four matching conversions are exercised, along with runs broken by a key change and runs that saturate. Low-bit jitter inside a run is also covered. Runs that start in bypass and complete in filtered mode are checked, as is a reset applied partway through a run.

// File: rtl/adc_filt_pkg.sv
package adc_filt_pkg;

  // Next run length: restart at 1 on a key change, else count up to a ceiling.
  function automatic int unsigned run_next(input int unsigned cur,
                                           input bit same_key,
                                           input int unsigned ceiling);
    if (!same_key)           return 1;
    else if (cur >= ceiling) return ceiling;
    else                     return cur + 1;
  endfunction

  // A run is settled once its length has reached the ceiling.
  function automatic bit run_settled(input int unsigned len,
                                     input int unsigned ceiling);
    return len >= ceiling;
  endfunction

endpackage

// File: rtl/afs_key_track.sv
module afs_key_track #(
  parameter int RES_W = 8,
  parameter int CMP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [RES_W-1:0] data,
  output logic [CMP_W-1:0] key,
  output logic             same
);
  logic [CMP_W-1:0] prev_key;

  assign key  = data[RES_W-1 -: CMP_W];
  assign same = (key == prev_key);

  always_ff @(posedge clk) begin
    if (rst)       prev_key <= '0;
    else if (take) prev_key <= key;
  end
endmodule

// File: rtl/afs_run_count.sv
module afs_run_count
  import adc_filt_pkg::*;
#(
  parameter int RUN_LEN = 4,
  parameter int CNT_W   = $clog2(RUN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             same,
  output logic [CNT_W-1:0] cnt,
  output logic             settled_nxt
);
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt     = CNT_W'(run_next(int'(unsigned'(cnt)), same, RUN_LEN));
    settled_nxt = run_settled(int'(unsigned'(cnt_nxt)), RUN_LEN);
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (take) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/afs_status_reg.sv
module afs_status_reg #(
  parameter int CMP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CMP_W-1:0] key,
  output logic [CMP_W-1:0] status_q,
  output logic             upd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      upd      <= 1'b0;
    end else begin
      upd <= wr;
      if (wr) status_q <= key;
    end
  end
endmodule

// File: rtl/adc_settle_filter.sv
module adc_settle_filter #(
  parameter int RES_W   = 8,
  parameter int CMP_W   = 6,
  parameter int RUN_LEN = 4,
  localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_valid,
  input  logic [RES_W-1:0] conv_data,
  input  logic             filt_bypass,
  output logic [CMP_W-1:0] status_q,
  output logic             status_upd
);
  // Named internal events, visible to the bound checker.
  logic [CMP_W-1:0] cur_key;
  logic             key_same;
  logic [CNT_W-1:0] run_cnt;
  logic             run_full;
  logic             wr_en;

  afs_key_track #(.RES_W(RES_W), .CMP_W(CMP_W)) u_key (
    .clk(clk), .rst(rst), .take(conv_valid), .data(conv_data),
    .key(cur_key), .same(key_same)
  );

  afs_run_count #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_run (
    .clk(clk), .rst(rst), .take(conv_valid), .same(key_same),
    .cnt(run_cnt), .settled_nxt(run_full)
  );

  assign wr_en = conv_valid && (filt_bypass || run_full);

  afs_status_reg #(.CMP_W(CMP_W)) u_stat (
    .clk(clk), .rst(rst), .wr(wr_en), .key(cur_key),
    .status_q(status_q), .upd(status_upd)
  );
endmodule

// File: rtl/adc_filter_chk.sv
module adc_filter_chk #(
  parameter int RES_W   = 8,
  parameter int CMP_W   = 6,
  parameter int RUN_LEN = 4,
  parameter int CNT_W   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             conv_valid,
  input logic [RES_W-1:0] conv_data,
  input logic             filt_bypass,
  input logic [CMP_W-1:0] status_q,
  input logic             status_upd,
  input logic             key_same,
  input logic [CNT_W-1:0] run_cnt
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (status_q == '0) && !status_upd && (run_cnt == '0));

  a_r2_short_run_silent: assert property (@(posedge clk) disable iff (rst)
    (conv_valid && !filt_bypass && key_same && (int'(run_cnt) < RUN_LEN - 1))
      |=> !status_upd);

  a_r4_change_silent: assert property (@(posedge clk) disable iff (rst)
    (conv_valid && !filt_bypass && !key_same) |=> !status_upd);

  a_r5_run_bounded: assert property (@(posedge clk) disable iff (rst)
    int'(run_cnt) <= RUN_LEN);

  a_r6_bypass_writes: assert property (@(posedge clk) disable iff (rst)
    (conv_valid && filt_bypass) |=>
      (status_upd && status_q == $past(conv_data[RES_W-1 -: CMP_W])));

  a_r7_upd_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (status_upd && !$past(rst)) |-> $past(conv_valid));

  a_r7_hold_when_quiet: assert property (@(posedge clk) disable iff (rst)
    (!status_upd && !$past(rst)) |-> $stable(status_q));
endmodule

bind adc_settle_filter adc_filter_chk #(
  .RES_W(RES_W), .CMP_W(CMP_W), .RUN_LEN(RUN_LEN), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_data(conv_data),
  .filt_bypass(filt_bypass), .status_q(status_q), .status_upd(status_upd),
  .key_same(key_same), .run_cnt(run_cnt)
);

// File: tb/test_adc_settle_filter.sv
module test_adc_settle_filter;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       conv_valid;
  logic [7:0] conv_data;
  logic       filt_bypass;
  logic [5:0] status_q;
  logic       status_upd;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  adc_settle_filter i_adc_settle_filter (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_data(conv_data),
    .filt_bypass(filt_bypass), .status_q(status_q), .status_upd(status_upd)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One conversion; checks outputs after the accepting edge.
  task automatic conv(input logic [7:0] d, input logic byp, input logic exp_upd,
                      input logic [5:0] exp_st, input string req);
    @(negedge clk);
    conv_valid  = 1'b1;
    conv_data   = d;
    filt_bypass = byp;
    @(posedge clk); #1;
    chk({req, " upd"}, int'(status_upd), int'(exp_upd));
    chk({req, " status"}, int'(status_q), int'(exp_st));
    @(negedge clk);
    conv_valid = 1'b0;
  endtask

  task automatic quiet(input logic [5:0] exp_st, input string req);
    @(negedge clk);
    conv_valid = 1'b0;
    conv_data  = 8'hFF;
    @(posedge clk); #1;
    chk({req, " quiet upd"}, int'(status_upd), 0);
    chk({req, " quiet status"}, int'(status_q), int'(exp_st));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; conv_valid = 1'b0;
    @(posedge clk); #1;
    chk("R1 status", int'(status_q), 0);
    chk("R1 upd", int'(status_upd), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // R2, R3: four matching keys with LSB jitter; write on the fourth.
  task automatic t_filtered_run();
    conv(8'hA4, 1'b0, 1'b0, 6'h00, "R2 run1");
    conv(8'hA5, 1'b0, 1'b0, 6'h00, "R3 run2 lsb jitter");
    conv(8'hA6, 1'b0, 1'b0, 6'h00, "R2 run3");
    conv(8'hA7, 1'b0, 1'b1, 6'h29, "R2 R3 run4 write");
    quiet(6'h29, "R7");
  endtask

  // R5, R4: saturated run rewrites; a change restarts at 1.
  task automatic t_saturate_restart();
    conv(8'hA4, 1'b0, 1'b1, 6'h29, "R5 saturated rewrite");
    conv(8'hA8, 1'b0, 1'b0, 6'h29, "R4 change no write");
    conv(8'hA9, 1'b0, 1'b0, 6'h29, "R4 run2");
    conv(8'hAA, 1'b0, 1'b0, 6'h29, "R4 run3");
    conv(8'hAB, 1'b0, 1'b1, 6'h2A, "R4 run4 write");
    quiet(6'h2A, "R7");
  endtask

  // R6: bypass writes every conversion.
  task automatic t_bypass();
    conv(8'h10, 1'b1, 1'b1, 6'h04, "R6 bypass a");
    conv(8'hFF, 1'b1, 1'b1, 6'h3F, "R6 bypass b");
    conv(8'h00, 1'b1, 1'b1, 6'h00, "R6 bypass c");
    quiet(6'h00, "R7");
  endtask

  // R8: run counted in bypass completes in filtered mode.
  task automatic t_bypass_history();
    conv(8'h80, 1'b1, 1'b1, 6'h20, "R8 byp run1");
    conv(8'h81, 1'b1, 1'b1, 6'h20, "R8 byp run2");
    conv(8'h82, 1'b1, 1'b1, 6'h20, "R8 byp run3");
    conv(8'h83, 1'b0, 1'b1, 6'h20, "R8 filtered run4 write");
    conv(8'h40, 1'b0, 1'b0, 6'h20, "R8 R4 change");
  endtask

  // R1: reset mid-run empties the history.
  task automatic t_reset_mid();
    conv(8'hC0, 1'b0, 1'b0, 6'h20, "R1 pre run1");
    conv(8'hC1, 1'b0, 1'b0, 6'h20, "R1 pre run2");
    conv(8'hC2, 1'b0, 1'b0, 6'h20, "R1 pre run3");
    do_reset();
    conv(8'hC3, 1'b0, 1'b0, 6'h00, "R1 post run1");
    conv(8'hC0, 1'b0, 1'b0, 6'h00, "R1 post run2");
    conv(8'hC1, 1'b0, 1'b0, 6'h00, "R1 post run3");
    conv(8'hC2, 1'b0, 1'b1, 6'h30, "R1 post run4 write");
  endtask

  initial begin
    rst = 1'b1; conv_valid = 1'b0; conv_data = 8'h00; filt_bypass = 1'b0;
    repeat (2) @(posedge clk);
    do_reset();
    t_filtered_run();
    t_saturate_restart();
    t_bypass();
    t_bypass_history();
    t_reset_mid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule